// File: doc/BRIEF.md
# Load Data Byte-Order and Width Formatter

This block sits between a data cache read port and the register write path of a vector-capable load unit. It takes a raw 64-bit word read from memory, together with the access size, a byte-reverse opcode flag and the current processor endianness. It restores the bytes to the order the register file expects. It then narrows or widens the value to the destination element width, either by plain truncation and zero extension or by signed or unsigned saturation. Finally it places the value in the correct element slot of a 64-bit register lane.

The access size is encoded in two bits: 0 is one byte, 1 is two bytes, 2 is four bytes and 3 is eight bytes. The destination element width uses the same code to mean 8, 16, 32 or 64 bits. The saturation code is 0 for off, 1 for signed, 2 for unsigned and 3 for off. The block is a single registered pipeline stage with a valid/ready handshake on both sides, and it produces exactly one result for each accepted input.

Top module: `ldfmt_top`

## Requirements
- R1: The bytes are reversed when the byte-reverse flag equals the little-endian flag (reverse = brev XNOR le). Otherwise they keep their memory order.
- R2: Reversal acts only on the lowest 1, 2, 4 or 8 bytes given by the access size. Bytes above the access size are discarded (treated as zero).
- R3: For a one-byte access, the reverse control has no effect on the result.
- R4: With saturation code 0 or 3, the value is zero-extended or truncated from the access width to the destination width w.
- R5: With saturation code 1, the value is sign-extended from the access width and clamped to the range -2^(w-1) to 2^(w-1)-1. The result is stored as w bits in two's complement.
- R6: With saturation code 2, the value is zero-extended and clamped to 2^w-1.
- R7: The w-bit result appears at bit offset (j*w) mod 64 of `out_data`, where j is the element index, and every other bit is zero. `out_mask` bit b is 1 exactly for the bytes the element occupies.
- R8: `out_roff` equals floor(j*w/64), the register offset from the base register.
- R9: `in_ready` is high when the output is empty or `out_ready` is high. A result is held unchanged while `out_valid` is high and `out_ready` is low. Each accepted input yields one result on the next cycle.
- R10: Synchronous active-high reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input |
| in_data | input | 64 | Raw memory read, byte 0 in bits 7:0 |
| in_opw | input | 2 | Access size code (1/2/4/8 bytes) |
| in_brev | input | 1 | Byte-reverse opcode flag |
| in_le | input | 1 | Processor little-endian flag |
| in_dstw | input | 2 | Destination element width code (8/16/32/64) |
| in_sat | input | 2 | Saturation code: 0 off, 1 signed, 2 unsigned, 3 off |
| in_idx | input | IDX_W | Destination element index j |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 64 | Element placed in its lane, other bits zero |
| out_mask | output | 8 | Byte-write mask for the lane |
| out_roff | output | IDX_W | Register offset j*w/64 |

## Verification
The main path is exercised with one known byte pattern under all four combinations of the reverse flag and the endianness flag, which separates the XNOR rule from a plain XOR rule or from ignoring either flag. Narrower accesses with non-zero upper bytes show whether the swap stays inside the access width and whether the stray bytes are dropped. Values just inside and outside the destination range, with both signs, tell truncation apart from signed and unsigned clamping. Element indices past the first register show whether the lane position, the byte mask and the register offset are derived correctly for each width.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  localparam int XLEN   = 64;
  localparam int NBYTES = XLEN / 8;

  typedef enum logic [1:0] {
    SZ_1 = 2'd0,
    SZ_2 = 2'd1,
    SZ_4 = 2'd2,
    SZ_8 = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    CLAMP_OFF  = 2'd0,
    CLAMP_SGN  = 2'd1,
    CLAMP_UNS  = 2'd2,
    CLAMP_OFF3 = 2'd3
  } clamp_e;
endpackage

// File: rtl/ldfmt_swap.sv
module ldfmt_swap
  import ldfmt_pkg::*;
(
  input  logic [XLEN-1:0] raw,
  input  size_e           size,
  input  logic            brev,
  input  logic            le,
  output logic [XLEN-1:0] ordered
);
  logic            do_rev;
  logic [XLEN-1:0] rev8;
  logic [31:0]     rev4;
  logic [15:0]     rev2;

  assign do_rev = ~(brev ^ le);

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_r8
      assign rev8[g*8 +: 8] = raw[(NBYTES-1-g)*8 +: 8];
    end
    for (g = 0; g < 4; g++) begin : g_r4
      assign rev4[g*8 +: 8] = raw[(3-g)*8 +: 8];
    end
    for (g = 0; g < 2; g++) begin : g_r2
      assign rev2[g*8 +: 8] = raw[(1-g)*8 +: 8];
    end
  endgenerate

  always_comb begin
    ordered = '0;
    unique case (size)
      SZ_1: ordered[7:0]  = raw[7:0];
      SZ_2: ordered[15:0] = do_rev ? rev2 : raw[15:0];
      SZ_4: ordered[31:0] = do_rev ? rev4 : raw[31:0];
      SZ_8: ordered       = do_rev ? rev8 : raw;
      default: ordered    = '0;
    endcase
  end
endmodule

// File: rtl/ldfmt_fit.sv
module ldfmt_fit
  import ldfmt_pkg::*;
(
  input  logic [XLEN-1:0] val,
  input  size_e           size,
  input  size_e           dstw,
  input  clamp_e          mode,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] sext;
  logic [XLEN-1:0] wmask;
  logic [XLEN-1:0] smax;
  logic [XLEN-1:0] smin;

  always_comb begin
    unique case (size)
      SZ_1:    sext = {{(XLEN-8){val[7]}},   val[7:0]};
      SZ_2:    sext = {{(XLEN-16){val[15]}}, val[15:0]};
      SZ_4:    sext = {{(XLEN-32){val[31]}}, val[31:0]};
      default: sext = val;
    endcase
    unique case (dstw)
      SZ_1:    wmask = 64'h0000_0000_0000_00FF;
      SZ_2:    wmask = 64'h0000_0000_0000_FFFF;
      SZ_4:    wmask = 64'h0000_0000_FFFF_FFFF;
      default: wmask = '1;
    endcase
    smax = wmask >> 1;
    smin = ~smax;
  end

  always_comb begin
    unique case (mode)
      CLAMP_SGN: begin
        if (dstw == SZ_8)                       res = sext;
        else if ($signed(sext) > $signed(smax)) res = smax;
        else if ($signed(sext) < $signed(smin)) res = smin & wmask;
        else                                    res = sext & wmask;
      end
      CLAMP_UNS: res = (val > wmask) ? wmask : val;
      default:   res = val & wmask;
    endcase
  end

  // R4, R5, R6: nothing is left above the destination width
  always_comb begin
    a_r4_width_clean: assert ((res & ~wmask) == '0);
    a_r6_unsigned_cap: assert (mode != CLAMP_UNS || res <= wmask);
  end
endmodule

// File: rtl/ldfmt_place.sv
module ldfmt_place
  import ldfmt_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [XLEN-1:0]   elem,
  input  size_e             dstw,
  input  logic [IDX_W-1:0]  idx,
  output logic [XLEN-1:0]   lane,
  output logic [NBYTES-1:0] bmask,
  output logic [IDX_W-1:0]  roff
);
  localparam int SH_W = $clog2(XLEN);

  logic [SH_W-1:0]   sh;
  logic [NBYTES-1:0] base;

  always_comb begin
    unique case (dstw)
      SZ_1: begin sh = {idx[2:0], 3'b000};    roff = idx >> 3; base = 8'h01; end
      SZ_2: begin sh = {idx[1:0], 4'b0000};   roff = idx >> 2; base = 8'h03; end
      SZ_4: begin sh = {idx[0],   5'b00000};  roff = idx >> 1; base = 8'h0F; end
      default: begin sh = '0;                 roff = idx;      base = 8'hFF; end
    endcase
    lane  = elem << sh;
    bmask = base << sh[SH_W-1:3];
  end
endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top
  import ldfmt_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [63:0]      in_data,
  input  logic [1:0]       in_opw,
  input  logic             in_brev,
  input  logic             in_le,
  input  logic [1:0]       in_dstw,
  input  logic [1:0]       in_sat,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [63:0]      out_data,
  output logic [7:0]       out_mask,
  output logic [IDX_W-1:0] out_roff
);
  logic [XLEN-1:0]   ordered;
  logic [XLEN-1:0]   fitted;
  logic [XLEN-1:0]   lane;
  logic [NBYTES-1:0] bmask;
  logic [IDX_W-1:0]  roff;
  logic              take;

  ldfmt_swap u_swap (
    .raw     (in_data),
    .size    (size_e'(in_opw)),
    .brev    (in_brev),
    .le      (in_le),
    .ordered (ordered)
  );

  ldfmt_fit u_fit (
    .val  (ordered),
    .size (size_e'(in_opw)),
    .dstw (size_e'(in_dstw)),
    .mode (clamp_e'(in_sat)),
    .res  (fitted)
  );

  ldfmt_place #(.IDX_W(IDX_W)) u_place (
    .elem  (fitted),
    .dstw  (size_e'(in_dstw)),
    .idx   (in_idx),
    .lane  (lane),
    .bmask (bmask),
    .roff  (roff)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= lane;
      out_mask <= bmask;
      out_roff <= roff;
    end
  end

  // R9: accepted input appears next cycle
  a_r9_accept: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);
  // R9: stalled result is held
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_mask) && $stable(out_roff)));
  // R7: data only inside the enabled bytes
  a_r7_data_in_mask: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_data & ~{{8{out_mask[7]}}, {8{out_mask[6]}}, {8{out_mask[5]}},
                                 {8{out_mask[4]}}, {8{out_mask[3]}}, {8{out_mask[2]}},
                                 {8{out_mask[1]}}, {8{out_mask[0]}}}) == 64'd0));
  // R7: mask covers 1, 2, 4 or 8 bytes
  a_r7_mask_size: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_mask) == 1 || $countones(out_mask) == 2 ||
                   $countones(out_mask) == 4 || $countones(out_mask) == 8));
endmodule

// File: tb/ldfmt_top_test.sv
module ldfmt_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  typedef struct packed {
    logic [63:0] d;
    logic [1:0]  opw;
    logic        brev;
    logic        le;
    logic [1:0]  dw;
    logic [1:0]  sat;
    logic [5:0]  idx;
    logic [63:0] ed;
    logic [7:0]  em;
    logic [5:0]  er;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] DA = 64'h8877_6655_4433_2211;
  localparam logic [63:0] DB = 64'hFFFF_FFFF_FFFF_FF80;
  localparam logic [63:0] DC = 64'h0000_0000_0000_1234;
  localparam logic [63:0] DD = 64'hABCD_0000_0000_8000;

  localparam vec_t VEC [NV] = '{
    '{DA, 2'd3, 1'b0, 1'b1, 2'd3, 2'd0, 6'd0,  64'h8877_6655_4433_2211, 8'hFF, 6'd0,  8'd1},  // R1 no swap
    '{DA, 2'd3, 1'b0, 1'b0, 2'd3, 2'd0, 6'd0,  64'h1122_3344_5566_7788, 8'hFF, 6'd0,  8'd1},  // R1 swap
    '{DA, 2'd3, 1'b1, 1'b1, 2'd3, 2'd0, 6'd0,  64'h1122_3344_5566_7788, 8'hFF, 6'd0,  8'd1},  // R1 swap
    '{DA, 2'd3, 1'b1, 1'b0, 2'd3, 2'd0, 6'd0,  64'h8877_6655_4433_2211, 8'hFF, 6'd0,  8'd1},  // R1 no swap
    '{DA, 2'd2, 1'b1, 1'b1, 2'd2, 2'd0, 6'd1,  64'h1122_3344_0000_0000, 8'hF0, 6'd0,  8'd2},  // R2 4B swap
    '{DA, 2'd1, 1'b0, 1'b0, 2'd1, 2'd0, 6'd5,  64'h0000_0000_1122_0000, 8'h0C, 6'd1,  8'd8},  // R8 2B
    '{DA, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 6'd13, 64'h0000_1100_0000_0000, 8'h20, 6'd1,  8'd3},  // R3 1B
    '{DA, 2'd3, 1'b0, 1'b1, 2'd1, 2'd0, 6'd0,  64'h0000_0000_0000_2211, 8'h03, 6'd0,  8'd4},  // R4 trunc
    '{DB, 2'd0, 1'b0, 1'b1, 2'd3, 2'd0, 6'd0,  64'h0000_0000_0000_0080, 8'hFF, 6'd0,  8'd4},  // R4 zext
    '{DB, 2'd0, 1'b0, 1'b1, 2'd3, 2'd1, 6'd0,  64'hFFFF_FFFF_FFFF_FF80, 8'hFF, 6'd0,  8'd5},  // R5 sext
    '{DB, 2'd2, 1'b0, 1'b1, 2'd0, 2'd1, 6'd0,  64'h0000_0000_0000_0080, 8'h01, 6'd0,  8'd5},  // R5 fits
    '{DC, 2'd1, 1'b0, 1'b1, 2'd0, 2'd1, 6'd0,  64'h0000_0000_0000_007F, 8'h01, 6'd0,  8'd5},  // R5 high clamp
    '{DD, 2'd1, 1'b0, 1'b1, 2'd0, 2'd1, 6'd0,  64'h0000_0000_0000_0080, 8'h01, 6'd0,  8'd5},  // R5 low clamp
    '{DC, 2'd1, 1'b0, 1'b1, 2'd0, 2'd2, 6'd0,  64'h0000_0000_0000_00FF, 8'h01, 6'd0,  8'd6},  // R6 clamp
    '{DC, 2'd1, 1'b0, 1'b1, 2'd1, 2'd2, 6'd0,  64'h0000_0000_0000_1234, 8'h03, 6'd0,  8'd6},  // R6 fits
    '{DB, 2'd3, 1'b0, 1'b1, 2'd2, 2'd2, 6'd3,  64'hFFFF_FFFF_0000_0000, 8'hF0, 6'd1,  8'd7},  // R6 R7 R8
    '{DC, 2'd1, 1'b0, 1'b1, 2'd0, 2'd3, 6'd0,  64'h0000_0000_0000_0034, 8'h01, 6'd0,  8'd4},  // R4 code 3
    '{64'h80, 2'd1, 1'b0, 1'b0, 2'd0, 2'd1, 6'd0, 64'h0000_0000_0000_0080, 8'h01, 6'd0, 8'd5}, // R5 after swap
    '{DA, 2'd3, 1'b0, 1'b1, 2'd3, 2'd0, 6'd63, 64'h8877_6655_4433_2211, 8'hFF, 6'd63, 8'd8}   // R8 last
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_data;
  logic [1:0]  in_opw;
  logic        in_brev;
  logic        in_le;
  logic [1:0]  in_dstw;
  logic [1:0]  in_sat;
  logic [5:0]  in_idx;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_data;
  logic [7:0]  out_mask;
  logic [5:0]  out_roff;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldfmt_top #(.IDX_W(6)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_opw(in_opw), .in_brev(in_brev), .in_le(in_le),
    .in_dstw(in_dstw), .in_sat(in_sat), .in_idx(in_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_mask(out_mask), .out_roff(out_roff)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_data = v.d;  in_opw = v.opw; in_brev = v.brev; in_le = v.le;
    in_dstw = v.dw; in_sat = v.sat; in_idx = v.idx;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 in_ready when empty", {63'd0, in_ready}, 64'd1);

    // vector table
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R9 valid vec%0d", k), {63'd0, out_valid}, 64'd1);
      chk($sformatf("R%0d data vec%0d", VEC[k].req, k), out_data, VEC[k].ed);
      chk($sformatf("R7 mask vec%0d", k), {56'd0, out_mask}, {56'd0, VEC[k].em});
      chk($sformatf("R8 roff vec%0d", k), {58'd0, out_roff}, {58'd0, VEC[k].er});
    end
    @(negedge clk);
    chk("R9 drains", {63'd0, out_valid}, 64'd0);

    // R9 backpressure: hold result, then stream next
    out_ready = 1'b0;
    drive(VEC[1]); in_valid = 1'b1;
    @(negedge clk);
    drive(VEC[7]);
    chk("R9 stall in_ready low", {63'd0, in_ready}, 64'd0);
    repeat (2) @(negedge clk);
    chk("R9 held data", out_data, VEC[1].ed);
    chk("R9 held valid", {63'd0, out_valid}, 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next result", out_data, VEC[7].ed);
    chk("R9 next mask", {56'd0, out_mask}, {56'd0, VEC[7].em});
    @(negedge clk);
    chk("R9 one result per input", {63'd0, out_valid}, 64'd0);

    // R3: one-byte access under every reverse control gives the same byte
    for (int m = 0; m < 4; m++) begin
      drive(VEC[6]); in_brev = m[0]; in_le = m[1]; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R3 single byte unaffected", out_data, VEC[6].ed);
    end

    // R10: reset while a result is waiting
    out_ready = 1'b0;
    drive(VEC[0]); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R10 reset clears pending", {63'd0, out_valid}, 64'd0);
    rst = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule